// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Bank

This block holds the interrupt-enable and interrupt-status registers for each of five localities. It also drives one level interrupt line that all localities share. Event pulses arrive with a locality tag and a four-bit source vector:

- data ready to read
- status became valid
- locality ownership changed
- ready for a new command

A pulse latches status bits only in a locality whose master enable and matching source enable are both set. Software clears status by writing ones. When a clearing write empties the status of the locality that wrote it, the shared line drops.

Register writes pass only for the locality that currently holds the interface. The active locality is supplied from outside. Reads work from any locality and return that locality's stored values. A fixed vector register reads a constant and ignores writes. Read data is registered and appears one cycle after the request.

Top module: `tis_irq_ctrl`

## Requirements
- R1: After reset, every locality's enable register reads 0x00000008 (low-level polarity code in bits 4:3, all sources and the master enable off). Every status register reads 0, `irq_o` is 0 and `rd_data` is 0.
- R2: Source vector bits map to status bits as follows: `evt_src` bit 0 to status bit 0, bit 1 to bit 1, bit 2 to bit 2, and bit 3 to bit 7. The master enable is enable bit 31.
  - An event sets a status bit only when the locality's master enable and the enable bit at that same position are both set.
  - A latched bit raises `irq_o` on the next clock edge.
- R3: An event whose `evt_loc` is 5 or above changes no status and does not raise `irq_o`.
- R4: A write to the enable or status register is ignored unless `act_vld` is 1 and `req_loc` equals `act_loc`.
- R5: An enable write changes only bits 31, 4:3, 7 and 2:0 (mask 0x8000009F). It changes them only in the byte lanes whose `req_be` bit is set; `req_be` bit n covers data bits 8n+7:8n.
- R6: A status write clears each status bit whose written bit is 1, within enabled lanes and inside mask 0x00000087. Written ones at other bit positions have no effect.
- R7: `irq_o` drops after a status write that leaves the writing locality's status at zero, even while another locality still holds status. It stays high while the writer keeps any bit set.
- R8: The vector register (`req_sel` = 2) always reads the value of parameter VEC_VALUE (default 0x0000000B), and writes to it change nothing.
- R9: A read request (`req_vld`=1, `req_we`=0) to enable (`req_sel`=0) or status (`req_sel`=1) returns that locality's stored value one cycle later, whichever locality is active.
- R10: When an event and a clearing write land in the same cycle, the event wins. The status becomes (old & ~cleared) | new, and `irq_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_vld | input | 1 | A locality currently holds the interface |
| act_loc | input | 3 | Index of the active locality |
| req_vld | input | 1 | Register access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_loc | input | 3 | Locality the access is made from |
| req_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 reserved (reads 0) |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| evt_vld | input | 1 | Event pulse |
| evt_loc | input | 3 | Locality the event belongs to |
| evt_src | input | 4 | Event sources, one bit each |
| irq_o | output | 1 | Shared level interrupt line |

## Verification
Every write and every event takes effect at the clock edge that samples it, so `irq_o` and the stored registers change one edge later. A read returns data one edge after its request. The bench drives all inputs on falling edges and samples outputs on the falling edge that follows the capturing rising edge. It reads stored values back through the read port with the one-cycle read latency. Each read-back therefore reflects every preceding write and event exactly once. After reset the bench waits out the two-stage reset release before its first check.

// File: rtl/tis_irq_pkg.sv
package tis_irq_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  localparam int unsigned DW       = 32;
  localparam int unsigned BEW      = DW / 8;
  localparam int unsigned SRC_N    = 4;
  localparam int unsigned GLB_BIT  = 31;

  // status/source bits: data ready 0, status valid 1, owner change 2, cmd ready 7
  localparam logic [DW-1:0] SRC_MASK  = 32'h0000_0087;
  localparam logic [DW-1:0] POL_MASK  = 32'h0000_0018;
  localparam logic [DW-1:0] EN_WMASK  = SRC_MASK | POL_MASK | (32'h1 << GLB_BIT);
  localparam logic [DW-1:0] EN_RESET  = 32'h0000_0008;

  function automatic logic [DW-1:0] src_to_bits(input logic [SRC_N-1:0] src);
    logic [DW-1:0] b;
    b    = '0;
    b[0] = src[0];
    b[1] = src[1];
    b[2] = src[2];
    b[7] = src[3];
    return b;
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [BEW-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < BEW; i++) begin
      m[i*8 +: 8] = {8{be[i]}};
    end
    return m;
  endfunction

endpackage

// File: rtl/tis_irq_bank.sv
module tis_irq_bank
  import tis_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic          st_wr,
  input  logic [DW-1:0] wmask,
  input  logic [DW-1:0] wdata,
  input  logic          evt_hit,
  input  logic [DW-1:0] evt_bits,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] st_q,
  output logic          set_any,
  output logic          cleared_zero
);

  logic [DW-1:0] set_bits;
  logic [DW-1:0] clr_bits;
  logic          clr_fire;
  logic [DW-1:0] st_d;
  logic [DW-1:0] en_d;
  logic          en_ce;
  logic          st_ce;

  always_comb begin
    set_bits     = (evt_hit && en_q[GLB_BIT]) ? (evt_bits & en_q & SRC_MASK) : '0;
    clr_bits     = st_wr ? (wdata & wmask & SRC_MASK) : '0;
    clr_fire     = (clr_bits != '0) && ((st_q & SRC_MASK) != '0);
    st_d         = (st_q & ~clr_bits) | set_bits;
    en_d         = (en_q & ~(wmask & EN_WMASK)) | (wdata & wmask & EN_WMASK);
    en_ce        = en_wr;
    st_ce        = evt_hit | st_wr;
    set_any      = |set_bits;
    cleared_zero = clr_fire && (st_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
      st_q <= '0;
    end else begin
      if (en_ce) en_q <= en_d;
      if (st_ce) st_q <= st_d;
    end
  end

endmodule

// File: rtl/tis_irq_line.sv
module tis_irq_line #(
  parameter int unsigned NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] raise_vec,
  input  logic [NUM_LOC-1:0] drop_vec,
  output logic               line_q
);

  logic line_d;

  always_comb begin
    if (|raise_vec)     line_d = 1'b1;
    else if (|drop_vec) line_d = 1'b0;
    else                line_d = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

endmodule

// File: rtl/tis_irq_ctrl.sv
module tis_irq_ctrl
  import tis_irq_pkg::*;
#(
  parameter int unsigned    NUM_LOC   = 5,
  parameter int unsigned    LOC_W     = 3,
  parameter logic [31:0]    VEC_VALUE = 32'h0000_000B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_vld,
  input  logic [LOC_W-1:0] act_loc,
  input  logic             req_vld,
  input  logic             req_we,
  input  logic [LOC_W-1:0] req_loc,
  input  logic [1:0]       req_sel,
  input  logic [3:0]       req_be,
  input  logic [31:0]      req_wdata,
  output logic [31:0]      rd_data,
  input  logic             evt_vld,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [3:0]       evt_src,
  output logic             irq_o
);

  localparam int unsigned FLAT_W = NUM_LOC * DW;

  logic [1:0]         rst_pipe;
  logic               rst_n_sync;
  logic               wr_own;
  logic [DW-1:0]      wmask;
  logic [DW-1:0]      evt_bits;
  logic [DW-1:0]      en_arr [NUM_LOC];
  logic [DW-1:0]      st_arr [NUM_LOC];
  logic [NUM_LOC-1:0] set_vec;
  logic [NUM_LOC-1:0] zero_vec;
  logic [FLAT_W-1:0]  en_flat;
  logic [FLAT_W-1:0]  st_flat;
  logic [DW-1:0]      rd_d;
  logic               rd_ce;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  always_comb begin
    wr_own   = req_vld && req_we && act_vld && (act_loc == req_loc) &&
               (32'(req_loc) < NUM_LOC);
    wmask    = lane_mask(req_be);
    evt_bits = src_to_bits(evt_src);
  end

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    logic sel_me;
    assign sel_me = (req_loc == LOC_W'(g));

    tis_irq_bank u_bank (
      .clk          (clk),
      .rst_n        (rst_n_sync),
      .en_wr        (wr_own && sel_me && (req_sel == SEL_ENABLE)),
      .st_wr        (wr_own && sel_me && (req_sel == SEL_STATUS)),
      .wmask        (wmask),
      .wdata        (req_wdata),
      .evt_hit      (evt_vld && (evt_loc == LOC_W'(g))),
      .evt_bits     (evt_bits),
      .en_q         (en_arr[g]),
      .st_q         (st_arr[g]),
      .set_any      (set_vec[g]),
      .cleared_zero (zero_vec[g])
    );

    assign en_flat[g*DW +: DW] = en_arr[g];
    assign st_flat[g*DW +: DW] = st_arr[g];
  end

  tis_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .raise_vec (set_vec),
    .drop_vec  (zero_vec),
    .line_q    (irq_o)
  );

  always_comb begin
    rd_d  = '0;
    rd_ce = req_vld && !req_we;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req_loc == LOC_W'(i)) begin
        if (req_sel == SEL_ENABLE) rd_d = en_arr[i];
        if (req_sel == SEL_STATUS) rd_d = st_arr[i];
      end
    end
    if (req_sel == SEL_VECTOR) rd_d = VEC_VALUE;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  rd_data <= '0;
    else if (rd_ce)   rd_data <= rd_d;
  end

endmodule

// File: rtl/tis_irq_chk.sv
module tis_irq_chk #(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned LOC_W     = 3,
  parameter logic [31:0] VEC_VALUE = 32'h0000_000B
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    act_vld,
  input logic [LOC_W-1:0]        act_loc,
  input logic                    req_vld,
  input logic                    req_we,
  input logic [LOC_W-1:0]        req_loc,
  input logic [1:0]              req_sel,
  input logic                    evt_vld,
  input logic [LOC_W-1:0]        evt_loc,
  input logic [31:0]             rd_data,
  input logic                    irq_o,
  input logic [NUM_LOC*32-1:0]   en_flat,
  input logic [NUM_LOC*32-1:0]   st_flat
);

  logic foreign_wr;
  logic any_wr;
  assign any_wr     = req_vld && req_we;
  assign foreign_wr = any_wr && (req_sel < 2'd2) &&
                      !(act_vld && (act_loc == req_loc) && (32'(req_loc) < NUM_LOC));

  // R2: the line only rises after an event pulse
  assert_rise_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(evt_vld));

  // R3: out-of-range event touches nothing
  assert_bad_loc_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && (32'(evt_loc) >= NUM_LOC) && !any_wr) |=> ($stable(st_flat) && $stable(irq_o)));

  // R4: writes from a locality that does not hold the interface change no register
  assert_foreign_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (foreign_wr && !evt_vld) |=> ($stable(st_flat) && $stable(en_flat)));

  // R7: the line only falls after a status write
  assert_fall_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(any_wr && (req_sel == 2'd1)));

  // R8: vector register reads its constant
  assert_vector_const_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_we && (req_sel == 2'd2)) |=> (rd_data == VEC_VALUE));

endmodule

bind tis_irq_ctrl tis_irq_chk #(
  .NUM_LOC   (NUM_LOC),
  .LOC_W     (LOC_W),
  .VEC_VALUE (VEC_VALUE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .act_vld (act_vld),
  .act_loc (act_loc),
  .req_vld (req_vld),
  .req_we  (req_we),
  .req_loc (req_loc),
  .req_sel (req_sel),
  .evt_vld (evt_vld),
  .evt_loc (evt_loc),
  .rd_data (rd_data),
  .irq_o   (irq_o),
  .en_flat (en_flat),
  .st_flat (st_flat)
);

// File: tb/tis_irq_ctrl_tb.sv
`timescale 1ns/100ps
module tis_irq_ctrl_tb;

  localparam int          NL  = 5;
  localparam logic [31:0] VEC = 32'h0000_000B;
  localparam logic [31:0] EWM = 32'h8000_009F;
  localparam logic [31:0] SMK = 32'h0000_0087;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_vld = 1'b0;
  logic [2:0]  act_loc = '0;
  logic        req_vld = 1'b0;
  logic        req_we = 1'b0;
  logic [2:0]  req_loc = '0;
  logic [1:0]  req_sel = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        evt_vld = 1'b0;
  logic [2:0]  evt_loc = '0;
  logic [3:0]  evt_src = '0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_en [NL];
  logic [31:0] m_st [NL];
  logic        m_irq;
  bit          m_actv;
  int          m_act;

  always #2.5 clk = ~clk;

  tis_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_loc(act_loc),
    .req_vld(req_vld), .req_we(req_we), .req_loc(req_loc), .req_sel(req_sel),
    .req_be(req_be), .req_wdata(req_wdata), .rd_data(rd_data),
    .evt_vld(evt_vld), .evt_loc(evt_loc), .evt_src(evt_src), .irq_o(irq_o)
  );

  function automatic logic [31:0] lanes(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] src_bits(input logic [3:0] s);
    return {24'b0, s[3], 4'b0, s[2:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic set_act(input bit v, input int l);
    @(negedge clk);
    act_vld = v;
    act_loc = 3'(l);
    m_actv  = v;
    m_act   = l;
  endtask

  task automatic wr(input int l, input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] c;
    @(negedge clk);
    req_vld = 1'b1; req_we = 1'b1; req_loc = 3'(l);
    req_sel = sel;  req_be = be;   req_wdata = d;
    if (m_actv && m_act == l && l < NL) begin
      if (sel == 2'd0) begin
        m_en[l] = (m_en[l] & ~(lanes(be) & EWM)) | (d & lanes(be) & EWM);
      end else if (sel == 2'd1) begin
        c = d & lanes(be) & SMK;
        if (c != 0 && m_st[l] != 0) begin
          m_st[l] = m_st[l] & ~c;
          if (m_st[l] == 0) m_irq = 1'b0;
        end
      end
    end
    @(negedge clk);
    req_vld = 1'b0; req_we = 1'b0;
  endtask

  task automatic ev(input int l, input logic [3:0] s);
    logic [31:0] set;
    @(negedge clk);
    evt_vld = 1'b1; evt_loc = 3'(l); evt_src = s;
    if (l < NL) begin
      if (m_en[l][31]) begin
        set = src_bits(s) & m_en[l] & SMK;
        m_st[l] = m_st[l] | set;
        if (set != 0) m_irq = 1'b1;
      end
    end
    @(negedge clk);
    evt_vld = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input int l, input logic [1:0] sel);
    logic [31:0] exp;
    @(negedge clk);
    req_vld = 1'b1; req_we = 1'b0; req_loc = 3'(l); req_sel = sel;
    @(negedge clk);
    req_vld = 1'b0;
    exp = (sel == 2'd2) ? VEC : (sel == 2'd0) ? m_en[l] : (sel == 2'd1) ? m_st[l] : 32'h0;
    check(tag, rd_data, exp);
  endtask

  task automatic chk_irq(input string tag);
    check(tag, {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_en[i] = 32'h0000_0008;
      m_st[i] = '0;
    end
    m_irq = 1'b0; m_actv = 1'b0; m_act = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    for (int l = 0; l < NL; l++) begin
      chk_reg("R1 enable", l, 2'd0);
      chk_reg("R1 status", l, 2'd1);
    end

    // R2 sweep: every locality, source and enable combination
    for (int l = 0; l < NL; l++) begin
      set_act(1'b1, l);
      for (int s = 0; s < 4; s++) begin
        for (int cfg = 0; cfg < 4; cfg++) begin
          wr(l, 2'd0, 4'hF, ({cfg[1], 31'b0}) | 32'h8 |
                           (cfg[0] ? src_bits(4'(1 << s)) : 32'h0));
          ev(l, 4'(1 << s));
          chk_irq("R2 irq after event");
          chk_reg("R2 status", l, 2'd1);
          wr(l, 2'd1, 4'hF, 32'h87);
          chk_irq("R7 irq after clear");
        end
      end
    end

    // R3 invalid event locality
    set_act(1'b1, 0);
    wr(0, 2'd0, 4'hF, 32'h8000_008F);
    ev(5, 4'hF);
    ev(7, 4'hF);
    chk_irq("R3 irq");
    chk_reg("R3 status loc0", 0, 2'd1);

    // R4 / R9 foreign writes ignored, reads from any locality
    ev(0, 4'hF);
    chk_irq("R2 irq set");
    set_act(1'b1, 1);
    wr(0, 2'd0, 4'hF, 32'h0);
    wr(0, 2'd1, 4'hF, 32'h87);
    chk_reg("R4 enable loc0 kept", 0, 2'd0);
    chk_reg("R4 status loc0 kept", 0, 2'd1);
    chk_irq("R4 irq kept");
    set_act(1'b0, 0);
    wr(0, 2'd1, 4'hF, 32'h87);
    chk_reg("R4 status no owner", 0, 2'd1);
    chk_reg("R9 read from non-owner", 0, 2'd0);

    // R5 enable write mask and lanes
    set_act(1'b1, 2);
    wr(2, 2'd0, 4'hF, 32'hFFFF_FFFF);
    chk_reg("R5 mask", 2, 2'd0);
    wr(2, 2'd0, 4'h1, 32'h0);
    chk_reg("R5 lane0", 2, 2'd0);
    wr(2, 2'd0, 4'h8, 32'h0);
    chk_reg("R5 lane3", 2, 2'd0);
    wr(2, 2'd0, 4'h1, 32'hFFFF_FFFF);
    chk_reg("R5 lane0 set", 2, 2'd0);

    // R6 write-one-to-clear
    set_act(1'b1, 0);
    wr(0, 2'd1, 4'hF, 32'hFFFF_FF78);
    chk_reg("R6 unsupported bits", 0, 2'd1);
    wr(0, 2'd1, 4'h0, 32'h87);
    chk_reg("R6 no lanes", 0, 2'd1);
    wr(0, 2'd1, 4'hF, 32'h01);
    chk_reg("R6 single clear", 0, 2'd1);
    chk_irq("R7 stays while bits remain");

    // R7 drop while another locality still holds status
    set_act(1'b1, 1);
    wr(1, 2'd0, 4'hF, 32'h8000_0081);
    ev(1, 4'h8);
    set_act(1'b1, 0);
    wr(0, 2'd1, 4'hF, 32'h86);
    chk_irq("R7 drop on writer zero");
    chk_reg("R7 other loc status", 1, 2'd1);

    // R8 vector register
    wr(0, 2'd2, 4'hF, 32'hFFFF_FFFF);
    chk_reg("R8 vector", 0, 2'd2);
    chk_reg("R8 vector other loc", 3, 2'd2);

    // R10 event and clear in the same cycle
    set_act(1'b1, 1);
    @(negedge clk);
    req_vld = 1'b1; req_we = 1'b1; req_loc = 3'd1; req_sel = 2'd1;
    req_be = 4'hF; req_wdata = 32'h80;
    evt_vld = 1'b1; evt_loc = 3'd1; evt_src = 4'h1;
    m_st[1] = 32'h01; m_irq = 1'b1;
    @(negedge clk);
    req_vld = 1'b0; req_we = 1'b0; evt_vld = 1'b0;
    chk_irq("R10 irq stays");
    chk_reg("R10 status", 1, 2'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule